// File: doc/BRIEF.md
# Reset Source Qualifier and Cause Recorder

This block sits between the raw reset sources of a chip and the reset sequencer. Each raw event (watchdog time-out, temperature alarm, core lockup, software system request, debug-port request) is gated by a software-programmed qualifier. The events that pass are presented, registered, on a request vector that the sequencer consumes. Every qualified event is also logged in a sticky cause register, so that boot software can find out why the last reset happened.

Software reaches the block through a plain word-addressed register port with a registered read path. The control register holds a 4-bit keyed gate field for the watchdog and for the temperature alarm, so that a single flipped bit cannot block either source. It also holds an enable bit for lockup and self-clearing command bits that ask for partial (core or debug) resets. A command bit stays set until the sequencer reports completion on a done input, and software reads a cleared bit as done.

The cause register combines write-1-to-clear flags with one plain read/write warm-boot bit and one read-only latch for watchdog events that arrived while the watchdog was gated. A small bank of scratch registers survives a warm reset, so that a resume address and its argument can be carried across it. A power-on reset wipes everything and leaves only the power-on flag set.

Top module: `rst_cause_ctrl`

## Requirements
- R1: After power-on reset the control register (address 0) reads 0x0000002A: watchdog key 0xA in bits [3:0], temperature key 0x2 in bits [7:4], lockup enable bit 8 clear, command bits 9 and 10 clear. The cause register (address 1) reads 0x00000001, every scratch register reads 0, and src_req_o and cmd_req_o are 0.
- R2: Source index 0 (watchdog) reaches src_req_o[0] one clock after src_evt_i[0] unless the watchdog key holds 0x5. Every other key value, 0xA included, lets it through.
- R3: Source index 1 (temperature) reaches src_req_o[1] one clock after src_evt_i[1] unless the temperature key holds 0x5. Every other key value, 0x2 included, lets it through.
- R4: Source index 2 (lockup) reaches src_req_o[2] and sets its cause flag only while control bit 8 is 1. While the bit is 0 a lockup event changes neither.
- R5: A watchdog event that arrives while the watchdog key holds 0x5 sets cause bit 7. The bit stays set after the event goes away, through writes of any value and through warm reset, and only power-on reset clears it.
- R6: Writing 1 to control bit 9+i sets cmd_req_o[i] and makes the bit read 1. Writing 0 there has no effect. A high cmd_done_i[i] clears it in the next cycle.
- R7: Cause bit 0 (power-on) and bits 1+k (qualified event on source k: 0 watchdog, 1 temperature, 2 lockup, 3 software request, 4 debug port) are sticky. Writing 1 to such a bit clears it, and writing 0 leaves it unchanged.
- R8: Cause bit 6 (warm boot) takes the written value on every write to the cause register. Writing 1 sets or keeps it and never clears it.
- R9: When a qualified event and a write-1-to-clear of its cause flag fall in the same cycle, the flag ends up set.
- R10: Power-on reset leaves the cause register at 0x00000001 and clears the warm-boot bit, the gated-watchdog latch and every scratch register.
- R11: Warm reset returns the control register to 0x0000002A, cancels pending commands and clears src_req_o. It leaves the cause register and the scratch registers unchanged.
- R12: Scratch register i sits at address 4+i (index 0 at address 4). It stores all 32 bits written to it.
- R13: rdata_o shows the register addressed with rd_en_i in the cycle after the request. Addresses with no register (2, 3, 8 to 15) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high, clears everything |
| warm_rst_i | input | 1 | Warm reset, synchronous, active high, keeps log and scratch registers |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| src_evt_i | input | 5 | Raw reset events: 0 watchdog, 1 temperature, 2 lockup, 3 software request, 4 debug port |
| src_req_o | output | 5 | Qualified, registered reset requests, same order |
| cmd_done_i | input | 2 | Completion of each partial-reset command |
| cmd_req_o | output | 2 | Pending partial-reset commands: 0 core, 1 debug |

## Verification
The bench targets the key fields with the blocking code, with the default code and with an unrelated code. A decoder that compares against the enabling key instead of the blocking one would gate the unrelated code. It clears cause flags with writes that also carry the warm-boot bit and the read-only latch bit. A design that treats bit 6 as write-1-to-clear, or lets software clear the latch, reads back the wrong value. A clear and a fresh event are driven into the same flag in one cycle, where a design that gives the clear priority loses the event. Warm and power-on resets are then applied with state everywhere, and a design that wipes the scratch bank on warm reset, or keeps the log across power-on, is caught.

// File: rtl/rcc_pkg.sv
`timescale 1ns/1ps
package rcc_pkg;
  // raw source indices
  localparam int NUM_SRC  = 5;
  localparam int SRC_WDOG = 0;
  localparam int SRC_TEMP = 1;
  localparam int SRC_LOCK = 2;
  localparam int SRC_SREQ = 3;
  localparam int SRC_DBGP = 4;

  // keyed gate codes
  localparam int          KEY_W      = 4;
  localparam logic [3:0]  KEY_BLOCK  = 4'h5;
  localparam logic [3:0]  WDOG_OPEN  = 4'hA;
  localparam logic [3:0]  TEMP_OPEN  = 4'h2;

  // control register layout
  localparam int WDOG_KEY_LSB = 0;
  localparam int TEMP_KEY_LSB = WDOG_KEY_LSB + KEY_W;
  localparam int LOCK_EN_BIT  = TEMP_KEY_LSB + KEY_W;
  localparam int CMD_LSB      = LOCK_EN_BIT + 1;

  // cause register layout
  localparam int POR_BIT   = 0;
  localparam int FLAG_LSB  = POR_BIT + 1;
  localparam int NUM_FLAG  = NUM_SRC + 1;
  localparam int WBOOT_BIT = FLAG_LSB + NUM_SRC;
  localparam int HELD_BIT  = WBOOT_BIT + 1;
  localparam int CAUSE_W   = HELD_BIT + 1;

  // register addresses
  localparam int CTRL_ADDR  = 0;
  localparam int CAUSE_ADDR = 1;

  typedef struct packed {
    logic             lock_en;
    logic [KEY_W-1:0] temp_key;
    logic [KEY_W-1:0] wdog_key;
  } gate_cfg_t;

  localparam gate_cfg_t GATE_DEFAULT = '{lock_en: 1'b0, temp_key: TEMP_OPEN, wdog_key: WDOG_OPEN};
endpackage

// File: rtl/rcc_ctrl_regs.sv
`timescale 1ns/1ps
module rcc_ctrl_regs
  import rcc_pkg::*;
#(
  parameter int NUM_CMD = 2
) (
  input  logic                       clk_i,
  input  logic                       por_i,
  input  logic                       warm_rst_i,
  input  logic                       wr_i,
  input  logic [CMD_LSB+NUM_CMD-1:0] wdata_i,
  input  logic [NUM_CMD-1:0]         cmd_done_i,
  output gate_cfg_t                  cfg_o,
  output logic [NUM_CMD-1:0]         cmd_o
);
  gate_cfg_t cfg_q;

  always_ff @(posedge clk_i) begin
    if (por_i || warm_rst_i) begin
      cfg_q <= GATE_DEFAULT;
    end else if (wr_i) begin
      cfg_q.wdog_key <= wdata_i[WDOG_KEY_LSB +: KEY_W];
      cfg_q.temp_key <= wdata_i[TEMP_KEY_LSB +: KEY_W];
      cfg_q.lock_en  <= wdata_i[LOCK_EN_BIT];
    end
  end

  // one self-clearing command flop per partial reset
  for (genvar i = 0; i < NUM_CMD; i++) begin : g_cmd
    logic pend_q;
    always_ff @(posedge clk_i) begin
      if (por_i || warm_rst_i) begin
        pend_q <= 1'b0;
      end else if (wr_i && wdata_i[CMD_LSB+i]) begin
        pend_q <= 1'b1;
      end else if (cmd_done_i[i]) begin
        pend_q <= 1'b0;
      end
    end
    assign cmd_o[i] = pend_q;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/rcc_src_qual.sv
`timescale 1ns/1ps
module rcc_src_qual
  import rcc_pkg::*;
(
  input  logic               clk_i,
  input  logic               por_i,
  input  logic               warm_rst_i,
  input  gate_cfg_t          cfg_i,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic [NUM_SRC-1:0] hit_o,
  output logic [NUM_SRC-1:0] req_o,
  output logic               held_o
);
  logic [NUM_SRC-1:0] pass;
  logic [NUM_SRC-1:0] req_q;
  logic               held_q;

  // gate per source: keyed fields block only on the blocking code
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_gate
    if (s == SRC_WDOG) begin : g_wdog
      assign pass[s] = (cfg_i.wdog_key != KEY_BLOCK);
    end else if (s == SRC_TEMP) begin : g_temp
      assign pass[s] = (cfg_i.temp_key != KEY_BLOCK);
    end else if (s == SRC_LOCK) begin : g_lock
      assign pass[s] = cfg_i.lock_en;
    end else begin : g_open
      assign pass[s] = 1'b1;
    end
  end

  assign hit_o = evt_i & pass;

  always_ff @(posedge clk_i) begin
    if (por_i || warm_rst_i) begin
      req_q <= '0;
    end else begin
      req_q <= hit_o;
    end
  end

  // gated watchdog latch survives warm reset
  always_ff @(posedge clk_i) begin
    if (por_i) begin
      held_q <= 1'b0;
    end else if (evt_i[SRC_WDOG] && !pass[SRC_WDOG]) begin
      held_q <= 1'b1;
    end
  end

  assign req_o  = req_q;
  assign held_o = held_q;
endmodule

// File: rtl/rcc_cause_log.sv
`timescale 1ns/1ps
module rcc_cause_log
  import rcc_pkg::*;
(
  input  logic               clk_i,
  input  logic               por_i,
  input  logic               wr_i,
  input  logic [WBOOT_BIT:0] wdata_i,
  input  logic [NUM_SRC-1:0] hit_i,
  input  logic               held_i,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [NUM_FLAG-1:0] flag_q;
  logic [NUM_FLAG-1:0] set_v;
  logic [NUM_FLAG-1:0] clr_v;
  logic                wboot_q;

  assign set_v = {hit_i, 1'b0};
  assign clr_v = wr_i ? wdata_i[NUM_FLAG-1:0] : '0;

  // set beats clear in the same cycle
  for (genvar f = 0; f < NUM_FLAG; f++) begin : g_flag
    always_ff @(posedge clk_i) begin
      if (por_i) begin
        flag_q[f] <= (f == POR_BIT);
      end else if (set_v[f]) begin
        flag_q[f] <= 1'b1;
      end else if (clr_v[f]) begin
        flag_q[f] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (por_i) begin
      wboot_q <= 1'b0;
    end else if (wr_i) begin
      wboot_q <= wdata_i[WBOOT_BIT];
    end
  end

  assign cause_o = {held_i, wboot_q, flag_q};
endmodule

// File: rtl/rcc_gp_bank.sv
`timescale 1ns/1ps
module rcc_gp_bank #(
  parameter int DATA_W  = 32,
  parameter int NUM_GPR = 4,
  parameter int IDX_W   = (NUM_GPR > 1) ? $clog2(NUM_GPR) : 1
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [NUM_GPR];

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_word
    always_ff @(posedge clk_i) begin
      if (por_i) begin
        mem_q[g] <= '0;
      end else if (we_i && (widx_i == IDX_W'(g))) begin
        mem_q[g] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < NUM_GPR; g++) begin
      if (ridx_i == IDX_W'(g)) rdata_o = mem_q[g];
    end
  end
endmodule

// File: rtl/rst_cause_ctrl.sv
`timescale 1ns/1ps
module rst_cause_ctrl
  import rcc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int NUM_GPR  = 4,
  parameter int GPR_BASE = 4,
  parameter int NUM_CMD  = 2
) (
  input  logic               clk_i,
  input  logic               por_i,
  input  logic               warm_rst_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] src_evt_i,
  output logic [NUM_SRC-1:0] src_req_o,
  input  logic [NUM_CMD-1:0] cmd_done_i,
  output logic [NUM_CMD-1:0] cmd_req_o
);
  localparam int CTRL_W = CMD_LSB + NUM_CMD;
  localparam int IDX_W  = (NUM_GPR > 1) ? $clog2(NUM_GPR) : 1;
  localparam logic [ADDR_W:0] GPR_LO = (ADDR_W+1)'(GPR_BASE);
  localparam logic [ADDR_W:0] GPR_HI = (ADDR_W+1)'(GPR_BASE + NUM_GPR);

  gate_cfg_t          cfg;
  logic [NUM_SRC-1:0] hit;
  logic               held;
  logic [CAUSE_W-1:0] cause;
  logic [DATA_W-1:0]  gpr_rd;
  logic               sel_ctrl, sel_cause, sel_gpr;
  logic [IDX_W-1:0]   gidx;
  logic [DATA_W-1:0]  rd_mux;
  logic [DATA_W-1:0]  rdata_q;

  // address decode
  assign sel_ctrl  = (addr_i == ADDR_W'(CTRL_ADDR));
  assign sel_cause = (addr_i == ADDR_W'(CAUSE_ADDR));
  assign sel_gpr   = ({1'b0, addr_i} >= GPR_LO) && ({1'b0, addr_i} < GPR_HI);
  assign gidx      = IDX_W'({1'b0, addr_i} - GPR_LO);

  rcc_ctrl_regs #(.NUM_CMD(NUM_CMD)) u_ctrl (
    .clk_i      (clk_i),
    .por_i      (por_i),
    .warm_rst_i (warm_rst_i),
    .wr_i       (wr_en_i && sel_ctrl),
    .wdata_i    (wdata_i[CTRL_W-1:0]),
    .cmd_done_i (cmd_done_i),
    .cfg_o      (cfg),
    .cmd_o      (cmd_req_o)
  );

  rcc_src_qual u_qual (
    .clk_i      (clk_i),
    .por_i      (por_i),
    .warm_rst_i (warm_rst_i),
    .cfg_i      (cfg),
    .evt_i      (src_evt_i),
    .hit_o      (hit),
    .req_o      (src_req_o),
    .held_o     (held)
  );

  rcc_cause_log u_log (
    .clk_i   (clk_i),
    .por_i   (por_i),
    .wr_i    (wr_en_i && sel_cause),
    .wdata_i (wdata_i[WBOOT_BIT:0]),
    .hit_i   (hit),
    .held_i  (held),
    .cause_o (cause)
  );

  rcc_gp_bank #(.DATA_W(DATA_W), .NUM_GPR(NUM_GPR), .IDX_W(IDX_W)) u_gpr (
    .clk_i   (clk_i),
    .por_i   (por_i),
    .we_i    (wr_en_i && sel_gpr),
    .widx_i  (gidx),
    .wdata_i (wdata_i),
    .ridx_i  (gidx),
    .rdata_o (gpr_rd)
  );

  // read mux, registered
  always_comb begin
    rd_mux = '0;
    if (sel_ctrl) begin
      rd_mux = DATA_W'({cmd_req_o, cfg.lock_en, cfg.temp_key, cfg.wdog_key});
    end else if (sel_cause) begin
      rd_mux = DATA_W'(cause);
    end else if (sel_gpr) begin
      rd_mux = gpr_rd;
    end
  end

  always_ff @(posedge clk_i) begin
    if (por_i) begin
      rdata_q <= '0;
    end else if (rd_en_i) begin
      rdata_q <= rd_mux;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/rcc_checker.sv
`timescale 1ns/1ps
module rcc_checker
  import rcc_pkg::*;
#(
  parameter int NUM_CMD = 2
) (
  input logic               clk_i,
  input logic               por_i,
  input logic               warm_rst_i,
  input logic [NUM_SRC-1:0] src_req_o,
  input logic [NUM_CMD-1:0] cmd_req_o,
  input logic [NUM_CMD-1:0] cmd_done_i,
  input gate_cfg_t          cfg,
  input logic [CAUSE_W-1:0] cause
);
  AST_WDOG_GATED: assert property (@(posedge clk_i) disable iff (por_i || warm_rst_i)
    (cfg.wdog_key == KEY_BLOCK) |=> !src_req_o[SRC_WDOG]); // R2
  AST_TEMP_GATED: assert property (@(posedge clk_i) disable iff (por_i || warm_rst_i)
    (cfg.temp_key == KEY_BLOCK) |=> !src_req_o[SRC_TEMP]); // R3
  AST_LOCK_GATED: assert property (@(posedge clk_i) disable iff (por_i || warm_rst_i)
    !cfg.lock_en |=> !src_req_o[SRC_LOCK]); // R4
  AST_HELD_STICKY: assert property (@(posedge clk_i) disable iff (por_i)
    cause[HELD_BIT] |=> cause[HELD_BIT]); // R5

  for (genvar c = 0; c < NUM_CMD; c++) begin : g_cmd_chk
    AST_CMD_PENDING: assert property (@(posedge clk_i) disable iff (por_i || warm_rst_i)
      (cmd_req_o[c] && !cmd_done_i[c]) |=> cmd_req_o[c]); // R6
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_log_chk
    AST_REQ_LOGGED: assert property (@(posedge clk_i) disable iff (por_i)
      src_req_o[s] |-> cause[FLAG_LSB+s]); // R9
  end

  AST_POR_CLEARS: assert property (@(posedge clk_i)
    por_i |=> (cause == CAUSE_W'(1))); // R10
endmodule

bind rst_cause_ctrl rcc_checker #(.NUM_CMD(NUM_CMD)) u_rcc_checker (
  .clk_i      (clk_i),
  .por_i      (por_i),
  .warm_rst_i (warm_rst_i),
  .src_req_o  (src_req_o),
  .cmd_req_o  (cmd_req_o),
  .cmd_done_i (cmd_done_i),
  .cfg        (cfg),
  .cause      (cause)
);

// File: tb/test_rst_cause_ctrl.sv
`timescale 1ns/1ps
module test_rst_cause_ctrl;
  logic        clk = 1'b0;
  logic        por = 1'b1;
  logic        warm = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  evt = '0;
  logic [4:0]  req;
  logic [1:0]  done = '0;
  logic [1:0]  cmd;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rst_cause_ctrl i_rst_cause_ctrl (
    .clk_i (clk), .por_i (por), .warm_rst_i (warm),
    .wr_en_i (wr_en), .rd_en_i (rd_en), .addr_i (addr),
    .wdata_i (wdata), .rdata_o (rdata),
    .src_evt_i (evt), .src_req_o (req),
    .cmd_done_i (done), .cmd_req_o (cmd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // drive one event cycle, return the registered request seen after it
  task automatic pulse(input logic [4:0] v, output logic [4:0] r);
    @(negedge clk);
    evt = v;
    @(negedge clk);
    evt = '0;
    r = req;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 src_req", 32'(req), 32'h0);
    chk("R1 cmd_req", 32'(cmd), 32'h0);
    rd(4'd0, d); chk("R1 ctrl", d, 32'h2A);
    rd(4'd1, d); chk("R1 cause", d, 32'h01);
    rd(4'd4, d); chk("R1 scratch0", d, 32'h0);
  endtask

  task automatic t_wdog();
    logic [4:0] r; logic [31:0] d;
    pulse(5'b00001, r); chk("R2 default key passes", 32'(r), 32'h01);
    wr(4'd0, 32'h25);
    pulse(5'b00001, r); chk("R2 key 0x5 blocks", 32'(r), 32'h00);
    repeat (3) @(negedge clk);
    rd(4'd1, d); chk("R5 held latch set", d & 32'h80, 32'h80);
    wr(4'd0, 32'h23);
    pulse(5'b00001, r); chk("R2 key 0x3 passes", 32'(r), 32'h01);
  endtask

  task automatic t_temp();
    logic [4:0] r;
    wr(4'd0, 32'h2A);
    pulse(5'b00010, r); chk("R3 default key passes", 32'(r), 32'h02);
    wr(4'd0, 32'h5A);
    pulse(5'b00010, r); chk("R3 key 0x5 blocks", 32'(r), 32'h00);
    wr(4'd0, 32'h7A);
    pulse(5'b00010, r); chk("R3 key 0x7 passes", 32'(r), 32'h02);
  endtask

  task automatic t_lockup();
    logic [4:0] r; logic [31:0] d;
    wr(4'd0, 32'h2A);
    pulse(5'b00100, r); chk("R4 lockup disabled req", 32'(r), 32'h00);
    rd(4'd1, d); chk("R4 lockup disabled flag", d & 32'h08, 32'h00);
    wr(4'd0, 32'h12A);
    pulse(5'b00100, r); chk("R4 lockup enabled req", 32'(r), 32'h04);
    rd(4'd1, d); chk("R4 lockup enabled flag", d & 32'h08, 32'h08);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    rd(4'd1, d); chk("R7 flags before clear", d, 32'h8F);
    wr(4'd1, 32'h02);
    rd(4'd1, d); chk("R7 w1c clears one flag", d, 32'h8D);
    wr(4'd1, 32'h00);
    rd(4'd1, d); chk("R7 zero write keeps flags", d, 32'h8D);
    wr(4'd1, 32'hBF);
    rd(4'd1, d); chk("R5 latch survives write", d, 32'h80);
  endtask

  task automatic t_wboot();
    logic [31:0] d;
    wr(4'd1, 32'h40);
    rd(4'd1, d); chk("R8 warm boot set", d, 32'hC0);
    wr(4'd1, 32'h40);
    rd(4'd1, d); chk("R8 writing 1 keeps it", d, 32'hC0);
    wr(4'd1, 32'h00);
    rd(4'd1, d); chk("R8 writing 0 clears it", d, 32'h80);
  endtask

  task automatic t_set_wins();
    logic [31:0] d; logic [4:0] r;
    @(negedge clk);
    evt = 5'b01000; wr_en = 1'b1; addr = 4'd1; wdata = 32'h10;
    @(negedge clk);
    evt = '0; wr_en = 1'b0;
    rd(4'd1, d); chk("R9 set beats clear", d, 32'h90);
    pulse(5'b10000, r); chk("R7 debug port req", 32'(r), 32'h10);
    rd(4'd1, d); chk("R7 debug port flag", d, 32'hB0);
  endtask

  task automatic t_cmd();
    logic [31:0] d;
    wr(4'd0, 32'h22A);
    chk("R6 core command pending", 32'(cmd), 32'h1);
    rd(4'd0, d); chk("R6 command bit reads 1", d, 32'h22A);
    wr(4'd0, 32'h02A);
    chk("R6 zero write no effect", 32'(cmd), 32'h1);
    @(negedge clk); done = 2'b01;
    @(negedge clk); done = 2'b00;
    chk("R6 done clears core", 32'(cmd), 32'h0);
    rd(4'd0, d); chk("R6 command reads done", d, 32'h02A);
    wr(4'd0, 32'h42A);
    chk("R6 debug command pending", 32'(cmd), 32'h2);
    @(negedge clk); done = 2'b10;
    @(negedge clk); done = 2'b00;
    chk("R6 done clears debug", 32'(cmd), 32'h0);
  endtask

  task automatic t_scratch();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) wr(4'(4 + i), 32'hC0DE_0000 + 32'(i * 17 + 1));
    for (int i = 0; i < 4; i++) begin
      rd(4'(4 + i), d); chk("R12 scratch readback", d, 32'hC0DE_0000 + 32'(i * 17 + 1));
    end
    rd(4'd3, d); chk("R13 unmapped 3", d, 32'h0);
    rd(4'd4, d);
    rd(4'd12, d); chk("R13 unmapped 12", d, 32'h0);
  endtask

  task automatic t_warm();
    logic [31:0] d;
    wr(4'd1, 32'h40);
    wr(4'd0, 32'h355);
    chk("R11 command armed", 32'(cmd), 32'h1);
    @(negedge clk); warm = 1'b1; evt = 5'b01000;
    @(negedge clk); warm = 1'b0; evt = '0;
    chk("R11 requests cleared", 32'(req), 32'h0);
    chk("R11 command cancelled", 32'(cmd), 32'h0);
    rd(4'd0, d); chk("R11 ctrl defaults", d, 32'h2A);
    rd(4'd1, d); chk("R11 cause kept", d, 32'hF0);
    rd(4'd4, d); chk("R11 scratch kept", d, 32'hC0DE_0001);
  endtask

  task automatic t_por();
    logic [31:0] d;
    @(negedge clk); por = 1'b1;
    repeat (2) @(negedge clk);
    por = 1'b0;
    rd(4'd1, d); chk("R10 cause after power-on", d, 32'h01);
    rd(4'd5, d); chk("R10 scratch cleared", d, 32'h0);
    rd(4'd0, d); chk("R10 ctrl defaults", d, 32'h2A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por = 1'b0;
    t_reset();
    t_wdog();
    t_temp();
    t_lockup();
    t_w1c();
    t_wboot();
    t_set_wins();
    t_cmd();
    t_scratch();
    t_warm();
    t_por();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule